// File: doc/BRIEF.md
# Fetch Address Translation Reuse Tracker

This block sits between an instruction fetch front end and an external address translation unit. It owns the program counter and keeps a cached physical fetch address. It also keeps a countdown of the instructions left before the end of the current 8 KB page. While that countdown is nonzero, a fetch reuses the cached physical address and no translation is requested. When the countdown is zero, a fetch raises a translation request and waits for the answer. Sequential steps advance both addresses together. A jump, whether absolute or relative, clears the countdown so that the next fetch must translate again.

A program counter with bit 0 set selects physical mode. In that mode the fetch address is taken straight from the program counter and the translation unit is left alone. A translation that faults is reported to the requester with its fault code, and the block keeps no page state from it. The translation unit and memory are outside the block. Commands and fetches are accepted only while the block is idle.

Top module: `fetch_xlate_reuse`

## Requirements
- R1: After reset the program counter is 0, the page countdown is 0, `fetch_valid` and `xlt_req` are low and `fetch_ready` is high.
- R2: A fetch with the countdown at 0 and program counter bit 0 clear drives `xlt_req` high from the next cycle, with `xlt_vaddr` equal to the program counter, until the cycle in which `xlt_rsp_valid` is seen. `fetch_valid` rises in the cycle after that response.
- R3: A response without fault loads the countdown with 2048 minus program counter bits [12:2]. The fetch result is the response address with bits [1:0] cleared, and that address becomes the cached physical address.
- R4: A fetch with a nonzero countdown and program counter bit 0 clear raises no translation. It returns the cached physical address with `fetch_valid` in the next cycle.
- R5: A step command (`cmd_op` = 2'b01) adds 4 to the program counter and to the cached physical address. It lowers the countdown by one when the countdown is nonzero and leaves a zero countdown at 0.
- R6: A load command (`cmd_op` = 2'b10) sets the program counter to `cmd_arg` and the countdown to 0.
- R7: An offset command (`cmd_op` = 2'b11) adds `cmd_arg` to the program counter and sets the countdown to 0.
- R8: A fetch with program counter bit 0 set raises no translation. In the next cycle it returns the program counter with bits [1:0] cleared, that address becomes the cached physical address, and the countdown becomes 1.
- R9: A response with `xlt_rsp_fault` high produces `fetch_valid` with `fetch_fault` high and `fetch_code` equal to `xlt_rsp_code` in the next cycle, and the countdown stays at 0.
- R10: While a translation is outstanding (`fetch_ready` low), commands and fetch requests are ignored. The program counter and countdown do not change, and no extra fetch result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command: 01 step, 10 load, 11 offset |
| cmd_arg | input | 64 | Load value or offset |
| fetch_req | input | 1 | Request a fetch address for the current program counter |
| fetch_ready | output | 1 | Idle; commands and fetches are accepted |
| fetch_valid | output | 1 | One-cycle strobe carrying a fetch result |
| fetch_paddr | output | 64 | Word-aligned physical fetch address |
| fetch_fault | output | 1 | Result is a translation fault |
| fetch_code | output | 4 | Fault code of a faulting result |
| xlt_req | output | 1 | Translation request, held until answered |
| xlt_vaddr | output | 64 | Virtual address to translate |
| xlt_rsp_valid | input | 1 | Translation answer strobe |
| xlt_rsp_fault | input | 1 | Translation failed |
| xlt_rsp_code | input | 4 | Fault code |
| xlt_rsp_paddr | input | 64 | Translated physical address |
| pc_o | output | 64 | Current program counter |
| page_left | output | 12 | Instructions left in the current page |

## Verification
The properties take three things about the inputs for granted. A translation answer arrives only while `xlt_req` is high. `cmd_valid` and `fetch_req` are never high in the same cycle. `cmd_op` is never 00 when `cmd_valid` is high. The stimulus drives every command and every fetch as a one-cycle pulse, in separate cycles, and its translation model answers only while it sees an open request, after a programmable delay. The one exception is the busy case: commands and fetches are sent on purpose while a request is open, to show they are ignored.

// File: rtl/fxr_pkg.sv
`timescale 1ns/1ps
package fxr_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_STEP = 2'b01,
    OP_LOAD = 2'b10,
    OP_OFFS = 2'b11
  } fxr_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } fxr_state_e;

endpackage

// File: rtl/fxr_pc_unit.sv
`timescale 1ns/1ps
module fxr_pc_unit
  import fxr_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_en,
  input  fxr_op_e           cmd_op,
  input  logic [ADDR_W-1:0] cmd_arg,
  output logic [ADDR_W-1:0] pc_q
);

  localparam logic [ADDR_W-1:0] STEP_BYTES = ADDR_W'(4);

  logic [ADDR_W-1:0] pc_d;

  always_comb begin
    pc_d = pc_q;
    unique case (cmd_op)
      OP_STEP: pc_d = pc_q + STEP_BYTES;
      OP_LOAD: pc_d = cmd_arg;
      OP_OFFS: pc_d = pc_q + cmd_arg;
      default: pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (cmd_en) begin
      pc_q <= pc_d;
    end
  end

endmodule

// File: rtl/fxr_page_count.sv
`timescale 1ns/1ps
module fxr_page_count #(
  parameter int PAGE_INSNS = 2048,
  localparam int IDX_W     = $clog2(PAGE_INSNS),
  localparam int CNT_W     = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clear,
  input  logic             load_one,
  input  logic             load_page,
  input  logic [IDX_W-1:0] page_idx,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cnt_zero
);

  localparam logic [CNT_W-1:0] FULL_PAGE = CNT_W'(PAGE_INSNS);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_zero = (cnt_q == '0);
  assign cnt_en   = step | clear | load_one | load_page;

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (load_page) begin
      cnt_d = FULL_PAGE - {1'b0, page_idx};
    end else if (load_one) begin
      cnt_d = CNT_W'(1);
    end else if (step && !cnt_zero) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fxr_fetch_ctrl.sv
`timescale 1ns/1ps
module fxr_fetch_ctrl
  import fxr_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic              cmd_valid,
  input  fxr_op_e           cmd_op,
  input  logic [ADDR_W-1:0] pc,
  input  logic              cnt_zero,
  input  logic              rsp_valid,
  input  logic              rsp_fault,
  input  logic [CODE_W-1:0] rsp_code,
  input  logic [ADDR_W-1:0] rsp_paddr,
  output logic              idle,
  output logic              cmd_en,
  output logic              cnt_step,
  output logic              cnt_clear,
  output logic              cnt_load_one,
  output logic              cnt_load_page,
  output logic              xlt_req,
  output logic              fetch_valid,
  output logic [ADDR_W-1:0] fetch_paddr,
  output logic              fetch_fault,
  output logic [CODE_W-1:0] fetch_code
);

  localparam logic [ADDR_W-1:0] WORD_MASK  = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] STEP_BYTES = ADDR_W'(4);

  fxr_state_e        state_q, state_d;
  logic [ADDR_W-1:0] paddr_q, paddr_d;
  logic              paddr_en;

  logic              fetch_go, phys_go, hit_go, miss_go;
  logic              rsp_take, rsp_ok, rsp_bad;
  logic [ADDR_W-1:0] phys_addr, rsp_addr;

  logic              fv_d;
  logic [ADDR_W-1:0] fpa_d;
  logic              ffault_d;
  logic [CODE_W-1:0] fcode_d;

  // Decode of the current request
  assign idle      = (state_q == ST_IDLE);
  assign cmd_en    = idle & cmd_valid & (cmd_op != OP_NONE);
  assign fetch_go  = idle & fetch_req & ~cmd_valid;
  assign phys_go   = fetch_go & pc[0];
  assign hit_go    = fetch_go & ~pc[0] & ~cnt_zero;
  assign miss_go   = fetch_go & ~pc[0] & cnt_zero;

  assign rsp_take  = (state_q == ST_WAIT) & rsp_valid;
  assign rsp_ok    = rsp_take & ~rsp_fault;
  assign rsp_bad   = rsp_take & rsp_fault;

  assign phys_addr = pc & WORD_MASK;
  assign rsp_addr  = rsp_paddr & WORD_MASK;

  // Countdown controls
  assign cnt_step      = cmd_en & (cmd_op == OP_STEP);
  assign cnt_clear     = cmd_en & ((cmd_op == OP_LOAD) | (cmd_op == OP_OFFS));
  assign cnt_load_one  = phys_go;
  assign cnt_load_page = rsp_ok;

  assign xlt_req = (state_q == ST_WAIT);

  // Next state
  always_comb begin
    state_d = state_q;
    if (miss_go) begin
      state_d = ST_WAIT;
    end else if (rsp_take) begin
      state_d = ST_IDLE;
    end
  end

  // Cached physical address
  always_comb begin
    paddr_en = phys_go | rsp_ok | cnt_step;
    paddr_d  = paddr_q;
    if (phys_go) begin
      paddr_d = phys_addr;
    end else if (rsp_ok) begin
      paddr_d = rsp_addr;
    end else if (cnt_step) begin
      paddr_d = paddr_q + STEP_BYTES;
    end
  end

  // Result formation
  always_comb begin
    fv_d     = phys_go | hit_go | rsp_take;
    ffault_d = rsp_bad;
    fcode_d  = rsp_bad ? rsp_code : '0;
    if (phys_go) begin
      fpa_d = phys_addr;
    end else if (rsp_ok) begin
      fpa_d = rsp_addr;
    end else if (rsp_bad) begin
      fpa_d = '0;
    end else begin
      fpa_d = paddr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q <= '0;
    end else if (paddr_en) begin
      paddr_q <= paddr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_valid <= 1'b0;
    end else begin
      fetch_valid <= fv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_paddr <= '0;
      fetch_fault <= 1'b0;
      fetch_code  <= '0;
    end else if (fv_d) begin
      fetch_paddr <= fpa_d;
      fetch_fault <= ffault_d;
      fetch_code  <= fcode_d;
    end
  end

endmodule

// File: rtl/fetch_xlate_reuse.sv
`timescale 1ns/1ps
module fetch_xlate_reuse
  import fxr_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PAGE_INSNS = 2048,
  parameter int CODE_W     = 4,
  localparam int IDX_W     = $clog2(PAGE_INSNS),
  localparam int CNT_W     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_arg,
  input  logic              fetch_req,
  output logic              fetch_ready,
  output logic              fetch_valid,
  output logic [ADDR_W-1:0] fetch_paddr,
  output logic              fetch_fault,
  output logic [CODE_W-1:0] fetch_code,
  output logic              xlt_req,
  output logic [ADDR_W-1:0] xlt_vaddr,
  input  logic              xlt_rsp_valid,
  input  logic              xlt_rsp_fault,
  input  logic [CODE_W-1:0] xlt_rsp_code,
  input  logic [ADDR_W-1:0] xlt_rsp_paddr,
  output logic [ADDR_W-1:0] pc_o,
  output logic [CNT_W-1:0]  page_left
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_ls = rst_pipe[1];

  fxr_op_e           op_e;
  logic [ADDR_W-1:0] pc_q;
  logic              cmd_en;
  logic              cnt_step, cnt_clear, cnt_load_one, cnt_load_page;
  logic              cnt_zero;
  logic [IDX_W-1:0]  page_idx;

  assign op_e     = fxr_op_e'(cmd_op);
  assign page_idx = pc_q[IDX_W+1:2];

  fxr_pc_unit #(
    .ADDR_W (ADDR_W)
  ) pc_i (
    .clk     (clk),
    .rst_n   (rst_ls),
    .cmd_en  (cmd_en),
    .cmd_op  (op_e),
    .cmd_arg (cmd_arg),
    .pc_q    (pc_q)
  );

  fxr_page_count #(
    .PAGE_INSNS (PAGE_INSNS)
  ) cnt_i (
    .clk       (clk),
    .rst_n     (rst_ls),
    .step      (cnt_step),
    .clear     (cnt_clear),
    .load_one  (cnt_load_one),
    .load_page (cnt_load_page),
    .page_idx  (page_idx),
    .cnt_q     (page_left),
    .cnt_zero  (cnt_zero)
  );

  fxr_fetch_ctrl #(
    .ADDR_W (ADDR_W),
    .CODE_W (CODE_W)
  ) ctrl_i (
    .clk           (clk),
    .rst_n         (rst_ls),
    .fetch_req     (fetch_req),
    .cmd_valid     (cmd_valid),
    .cmd_op        (op_e),
    .pc            (pc_q),
    .cnt_zero      (cnt_zero),
    .rsp_valid     (xlt_rsp_valid),
    .rsp_fault     (xlt_rsp_fault),
    .rsp_code      (xlt_rsp_code),
    .rsp_paddr     (xlt_rsp_paddr),
    .idle          (fetch_ready),
    .cmd_en        (cmd_en),
    .cnt_step      (cnt_step),
    .cnt_clear     (cnt_clear),
    .cnt_load_one  (cnt_load_one),
    .cnt_load_page (cnt_load_page),
    .xlt_req       (xlt_req),
    .fetch_valid   (fetch_valid),
    .fetch_paddr   (fetch_paddr),
    .fetch_fault   (fetch_fault),
    .fetch_code    (fetch_code)
  );

  assign xlt_vaddr = pc_q;
  assign pc_o      = pc_q;

endmodule

// File: rtl/fxr_checker.sv
`timescale 1ns/1ps
module fxr_checker #(
  parameter int ADDR_W     = 64,
  parameter int PAGE_INSNS = 2048,
  localparam int IDX_W     = $clog2(PAGE_INSNS),
  localparam int CNT_W     = IDX_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_arg,
  input logic              fetch_req,
  input logic              fetch_ready,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_paddr,
  input logic              fetch_fault,
  input logic              xlt_req,
  input logic [ADDR_W-1:0] xlt_vaddr,
  input logic              xlt_rsp_valid,
  input logic              xlt_rsp_fault,
  input logic [ADDR_W-1:0] pc_o,
  input logic [CNT_W-1:0]  page_left
);

  localparam logic [CNT_W-1:0]  FULL_PAGE = CNT_W'(PAGE_INSNS);
  localparam logic [ADDR_W-1:0] FOUR      = ADDR_W'(4);

  logic fetch_go;
  assign fetch_go = fetch_ready & fetch_req & ~cmd_valid;

  // R2: request is held with a steady address until answered
  p_xlt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xlt_req && !xlt_rsp_valid |=> xlt_req && $stable(xlt_vaddr));

  // R2: a miss opens a request for the program counter
  p_miss_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go && !pc_o[0] && page_left == '0 |=>
      xlt_req && xlt_vaddr == $past(pc_o) && !fetch_valid);

  // R2: the answer produces a result in the following cycle
  p_rsp_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xlt_req && xlt_rsp_valid |=> fetch_valid && !xlt_req);

  // R3: countdown loaded from the page index of the translated address
  p_page_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xlt_req && xlt_rsp_valid && !xlt_rsp_fault |=>
      page_left == FULL_PAGE - CNT_W'($past(xlt_vaddr[IDX_W+1:2])) && !fetch_fault);

  // R4: reuse without translation
  p_hit_reuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go && !pc_o[0] && page_left != '0 |=>
      fetch_valid && !xlt_req && !fetch_fault && $stable(page_left));

  // R5: step command
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready && cmd_valid && cmd_op == 2'b01 |=>
      pc_o == $past(pc_o) + FOUR &&
      page_left == (($past(page_left) == '0) ? '0 : $past(page_left) - CNT_W'(1)));

  // R6: load command
  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready && cmd_valid && cmd_op == 2'b10 |=>
      pc_o == $past(cmd_arg) && page_left == '0);

  // R7: offset command
  p_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready && cmd_valid && cmd_op == 2'b11 |=>
      pc_o == $past(pc_o) + $past(cmd_arg) && page_left == '0);

  // R8: physical mode bypass
  p_phys_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go && pc_o[0] |=>
      fetch_valid && !xlt_req && page_left == CNT_W'(1) &&
      fetch_paddr == {$past(pc_o[ADDR_W-1:2]), 2'b00});

  // R9: fault passes through, countdown kept at zero
  p_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xlt_req && xlt_rsp_valid && xlt_rsp_fault |=>
      fetch_valid && fetch_fault && page_left == '0);

  // R10: nothing moves while a request is open
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xlt_req && !xlt_rsp_valid |=> $stable(pc_o) && $stable(page_left));

  // R10: no result while busy
  p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xlt_req |-> !fetch_valid && !fetch_ready);

endmodule

bind fetch_xlate_reuse fxr_checker #(
  .ADDR_W     (ADDR_W),
  .PAGE_INSNS (PAGE_INSNS)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_ls),
  .cmd_valid     (cmd_valid),
  .cmd_op        (cmd_op),
  .cmd_arg       (cmd_arg),
  .fetch_req     (fetch_req),
  .fetch_ready   (fetch_ready),
  .fetch_valid   (fetch_valid),
  .fetch_paddr   (fetch_paddr),
  .fetch_fault   (fetch_fault),
  .xlt_req       (xlt_req),
  .xlt_vaddr     (xlt_vaddr),
  .xlt_rsp_valid (xlt_rsp_valid),
  .xlt_rsp_fault (xlt_rsp_fault),
  .pc_o          (pc_o),
  .page_left     (page_left)
);

// File: tb/fetch_xlate_reuse_tb_top.sv
`timescale 1ns/1ps
module fetch_xlate_reuse_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [63:0] cmd_arg;
  logic        fetch_req;
  logic        fetch_ready;
  logic        fetch_valid;
  logic [63:0] fetch_paddr;
  logic        fetch_fault;
  logic [3:0]  fetch_code;
  logic        xlt_req;
  logic [63:0] xlt_vaddr;
  logic        xlt_rsp_valid;
  logic        xlt_rsp_fault;
  logic [3:0]  xlt_rsp_code;
  logic [63:0] xlt_rsp_paddr;
  logic [63:0] pc_o;
  logic [11:0] page_left;

  fetch_xlate_reuse dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cmd_arg       (cmd_arg),
    .fetch_req     (fetch_req),
    .fetch_ready   (fetch_ready),
    .fetch_valid   (fetch_valid),
    .fetch_paddr   (fetch_paddr),
    .fetch_fault   (fetch_fault),
    .fetch_code    (fetch_code),
    .xlt_req       (xlt_req),
    .xlt_vaddr     (xlt_vaddr),
    .xlt_rsp_valid (xlt_rsp_valid),
    .xlt_rsp_fault (xlt_rsp_fault),
    .xlt_rsp_code  (xlt_rsp_code),
    .xlt_rsp_paddr (xlt_rsp_paddr),
    .pc_o          (pc_o),
    .page_left     (page_left)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_vec;
  int n_bad;
  bit finished;

  // Bench model
  logic [63:0] m_pc;
  logic [63:0] m_pa;
  int          m_cnt;
  int          exp_xlt;
  int          seen_xlt;
  int          xlt_lat;
  int          wcnt;

  // Scoreboard
  logic        q_fault[$];
  logic [3:0]  q_code[$];
  logic [63:0] q_pa[$];
  string       q_tag[$];

  function automatic logic [63:0] xl_map(input logic [63:0] v);
    return v ^ 64'h0000_0123_4560_0000;
  endfunction

  function automatic bit xl_faults(input logic [63:0] v);
    return v[47:44] == 4'hE;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // Translation responder
  always @(negedge clk) begin
    if (xlt_rsp_valid) begin
      xlt_rsp_valid = 1'b0;
      xlt_rsp_fault = 1'b0;
    end else if (rst_n && xlt_req) begin
      if (wcnt >= xlt_lat) begin
        check(xlt_vaddr == m_pc, "R2 xlt_vaddr", xlt_vaddr, m_pc);
        xlt_rsp_valid = 1'b1;
        xlt_rsp_fault = xl_faults(xlt_vaddr);
        xlt_rsp_code  = xlt_vaddr[43:40];
        xlt_rsp_paddr = xl_map(xlt_vaddr);
        seen_xlt++;
        wcnt = 0;
      end else begin
        wcnt++;
      end
    end
  end

  // Monitor
  always @(negedge clk) begin
    if (rst_n && fetch_valid) begin
      if (q_pa.size() == 0) begin
        check(1'b0, "R10 unexpected fetch_valid", fetch_paddr, 64'h0);
      end else begin
        automatic logic        ef = q_fault.pop_front();
        automatic logic [3:0]  ec = q_code.pop_front();
        automatic logic [63:0] ea = q_pa.pop_front();
        automatic string       et = q_tag.pop_front();
        check(fetch_fault == ef, {et, " fault flag"}, 64'(fetch_fault), 64'(ef));
        if (ef) check(fetch_code == ec, {et, " fault code"}, 64'(fetch_code), 64'(ec));
        else    check(fetch_paddr == ea, {et, " paddr"}, fetch_paddr, ea);
      end
    end
  end

  task automatic issue_cmd(input logic [1:0] op, input logic [63:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_arg   = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 2'b00;
    case (op)
      2'b01: begin m_pc = m_pc + 64'd4; m_pa = m_pa + 64'd4; if (m_cnt != 0) m_cnt--; end
      2'b10: begin m_pc = arg; m_cnt = 0; end
      2'b11: begin m_pc = m_pc + arg; m_cnt = 0; end
      default: ;
    endcase
  endtask

  task automatic push_exp(input logic f, input logic [3:0] c,
                          input logic [63:0] a, input string t);
    q_fault.push_back(f);
    q_code.push_back(c);
    q_pa.push_back(a);
    q_tag.push_back(t);
  endtask

  task automatic model_fetch();
    if (m_pc[0]) begin
      m_pa  = m_pc & ~64'h3;
      m_cnt = 1;
      push_exp(1'b0, 4'h0, m_pa, "R8 physical");
    end else if (m_cnt != 0) begin
      push_exp(1'b0, 4'h0, m_pa, "R4 reuse");
    end else begin
      exp_xlt++;
      if (xl_faults(m_pc)) begin
        push_exp(1'b1, m_pc[43:40], 64'h0, "R9 fault");
      end else begin
        m_pa  = xl_map(m_pc) & ~64'h3;
        m_cnt = 2048 - int'(m_pc[12:2]);
        push_exp(1'b0, 4'h0, m_pa, "R3 translated");
      end
    end
  endtask

  task automatic do_fetch();
    @(negedge clk);
    model_fetch();
    fetch_req = 1'b1;
    @(negedge clk);
    fetch_req = 1'b0;
    while (q_pa.size() != 0) @(negedge clk);
  endtask

  task automatic chk_state(input string tag);
    @(negedge clk);
    check(pc_o == m_pc, {tag, " pc"}, pc_o, m_pc);
    check(page_left == 12'(m_cnt), {tag, " page_left"}, 64'(page_left), 64'(m_cnt));
  endtask

  task automatic chk_xlt(input string tag);
    check(seen_xlt == exp_xlt, {tag, " translation count"}, 64'(seen_xlt), 64'(exp_xlt));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; finished = 0;
    m_pc = 0; m_pa = 0; m_cnt = 0; exp_xlt = 0; seen_xlt = 0;
    xlt_lat = 0; wcnt = 0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_arg = '0; fetch_req = 1'b0;
    xlt_rsp_valid = 1'b0; xlt_rsp_fault = 1'b0; xlt_rsp_code = '0; xlt_rsp_paddr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check(pc_o == 64'h0, "R1 pc", pc_o, 64'h0);
    check(page_left == 12'h0, "R1 page_left", 64'(page_left), 64'h0);
    check(!fetch_valid && !xlt_req, "R1 strobes", 64'({fetch_valid, xlt_req}), 64'h0);
    check(fetch_ready, "R1 ready", 64'(fetch_ready), 64'h1);

    // R6, R2, R3: load at page start, translate
    issue_cmd(2'b10, 64'h0000_0000_1000_0000);
    chk_state("R6 load");
    do_fetch();
    chk_state("R3 full page");
    chk_xlt("R2 first miss");

    // R4, R5: reuse after steps
    do_fetch();
    repeat (3) issue_cmd(2'b01, 64'h0);
    chk_state("R5 step");
    do_fetch();
    chk_xlt("R4 no new translation");

    // R5, R2: page boundary with slow translation
    xlt_lat = 3;
    issue_cmd(2'b10, 64'h0000_0000_2000_1FFC);
    do_fetch();
    chk_state("R3 last slot");
    issue_cmd(2'b01, 64'h0);
    chk_state("R5 count reaches zero");
    do_fetch();
    chk_xlt("R2 page crossing");

    // R7: offset forces retranslation
    issue_cmd(2'b11, 64'h0000_0000_0000_0040);
    chk_state("R7 offset");
    do_fetch();
    chk_xlt("R7 retranslate");

    // R8: physical mode
    issue_cmd(2'b10, 64'h0000_0000_0030_0001);
    do_fetch();
    chk_state("R8 count one");
    issue_cmd(2'b01, 64'h0);
    do_fetch();
    chk_xlt("R8 no translation");

    // R9: fault, then a retry translates again
    xlt_lat = 1;
    issue_cmd(2'b10, 64'h0000_E300_0000_0000);
    do_fetch();
    chk_state("R9 count stays zero");
    do_fetch();
    chk_xlt("R9 retry");
    // R5: step with zero count stays zero
    issue_cmd(2'b01, 64'h0);
    chk_state("R5 zero hold");

    // R10: commands and fetches ignored while waiting
    xlt_lat = 5;
    issue_cmd(2'b10, 64'h0000_0000_4000_0100);
    @(negedge clk);
    model_fetch();
    fetch_req = 1'b1;
    @(negedge clk);
    fetch_req = 1'b0;
    cmd_valid = 1'b1; cmd_op = 2'b10; cmd_arg = 64'h0000_0000_DEAD_0000;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    fetch_req = 1'b1;
    @(negedge clk);
    fetch_req = 1'b0;
    while (q_pa.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk_state("R10 busy ignore");
    chk_xlt("R10 single translation");

    // R4, R3: long sequential run across a page edge
    xlt_lat = 0;
    issue_cmd(2'b10, 64'h0000_0000_3000_1F00);
    do_fetch();
    chk_state("R3 mid page");
    for (int i = 0; i < 70; i++) begin
      issue_cmd(2'b01, 64'h0);
      do_fetch();
    end
    chk_state("R4 after run");
    chk_xlt("R4 one crossing");

    repeat (3) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end

endmodule